// File: doc/BRIEF.md
# Idle-Tolerant Watchdog Counter

This block is a 15-bit watchdog counter for a processor core. Once enabled it climbs by one on every prescaler tick. Software is expected to restart it with a refresh strobe before it passes its all-ones state. If the counter passes all-ones while the core is running normally, the block raises a single-cycle system reset request and begins a new count.

Idle mode does not stop the count. When the overflow falls inside idle, the block reloads the counter and keeps counting, and it raises no reset request. Software therefore plans a timed wake-up well before the top of the range, for instance near 7F00h when 7FFCh is the last safe point. It then refreshes, and it may refresh in the first cycle after leaving idle. The refresh and reload value is a parameter. A reset clears the counter to zero.

Top module: `idle_wdt`

## Requirements
- R1: While reset is asserted, and after its release, `count_o` is 0 and `rst_req_o` is 0 until the first tick.
- R2: With `enable_i` high and no refresh, the counter rises by exactly one every `PRESCALE_DIV` clock cycles. The prescaler starts from phase 0 after reset or after a refresh, so the first increment comes at the `PRESCALE_DIV`-th rising edge.
- R3: With `enable_i` low, the counter and the prescaler phase both hold their values.
- R4: A refresh loads `START_VAL` at the next edge and clears the prescaler phase. It does this whatever the values of `enable_i` and `idle_i`, and it wins over an increment falling in the same cycle.
- R5: Asserting `idle_i` does not slow or stop the count.
- R6: A tick taken at all-ones with `idle_i` low reloads `START_VAL` and drives `rst_req_o` high for exactly one cycle, both at the same edge.
- R7: A tick taken at all-ones with `idle_i` high reloads `START_VAL` and leaves `rst_req_o` low.
- R8: `rst_req_o` goes high only after an overflow tick. A refresh in the cycle where that tick would have come prevents the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset, active low. Assertion is asynchronous and release is synchronised inside the block. |
| idle_i | input | 1 | High while the core is in idle mode |
| enable_i | input | 1 | Count enable. It also gates the prescaler. |
| refresh_i | input | 1 | Refresh strobe that reloads the start value |
| count_o | output | CNT_W (15) | Current counter value |
| rst_req_o | output | 1 | System reset request, one cycle wide |

## Verification
The hardest situation to reach from the ports is an overflow landing inside an idle window. The bench must also show that the window produced no reset pulse at all, not merely that none is present at the final sample. The bench sets `START_VAL` close to the top of the range so that overflow arrives within a few dozen cycles. It holds `idle_i` high across the wrap and counts request pulses on every cycle of that window. A second close case puts a refresh in exactly the cycle in which the overflow tick would have arrived. The bench reaches it by counting prescaler phases from a known refresh point.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // What the counter does at the next edge
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_LOAD = 2'd2,
    ACT_WRAP = 2'd3
  } wdt_act_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic clear_i,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  generate
    if (DIV <= 1) begin : g_direct
      assign tick_o = enable_i && !clear_i;
    end else begin : g_div
      logic [PW-1:0] phase_q, phase_d;

      always_comb begin
        phase_d = phase_q;
        if (clear_i) begin
          phase_d = '0;
        end else if (enable_i) begin
          phase_d = (phase_q == LAST) ? '0 : phase_q + PW'(1);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          phase_q <= '0;
        end else begin
          phase_q <= phase_d;
        end
      end

      assign tick_o = enable_i && !clear_i && (phase_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned      CNT_W     = 15,
  parameter logic [CNT_W-1:0] START_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             refresh_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  wdt_act_e         act;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (refresh_i)            act = ACT_LOAD;
    else if (!tick_i)         act = ACT_HOLD;
    else if (cnt_q == TOP)    act = ACT_WRAP;
    else                      act = ACT_STEP;
  end

  always_comb begin
    case (act)
      ACT_STEP: cnt_d = cnt_q + CNT_W'(1);
      ACT_LOAD,
      ACT_WRAP: cnt_d = START_VAL;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (act != ACT_HOLD) begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;
  assign wrap_o  = (act == ACT_WRAP);
endmodule

// File: rtl/wdt_req_gen.sv
module wdt_req_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_i,
  input  logic idle_i,
  output logic req_o
);
  logic req_q, req_d;

  // Wraps during idle are absorbed silently
  always_comb req_d = wrap_i && !idle_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/idle_wdt.sv
module idle_wdt #(
  parameter int unsigned      CNT_W        = 15,
  parameter int unsigned      PRESCALE_DIV = 12,
  parameter logic [CNT_W-1:0] START_VAL    = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_i,
  input  logic             enable_i,
  input  logic             refresh_i,
  output logic [CNT_W-1:0] count_o,
  output logic             rst_req_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       tick;
  logic       wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  wdt_prescaler #(.DIV(PRESCALE_DIV)) u_psc (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .enable_i (enable_i),
    .clear_i  (refresh_i),
    .tick_o   (tick)
  );

  wdt_counter #(.CNT_W(CNT_W), .START_VAL(START_VAL)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick_i    (tick),
    .refresh_i (refresh_i),
    .count_o   (count_o),
    .wrap_o    (wrap)
  );

  wdt_req_gen u_req (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wrap_i (wrap),
    .idle_i (idle_i),
    .req_o  (rst_req_o)
  );
endmodule

// File: rtl/idle_wdt_chk.sv
module idle_wdt_chk #(
  parameter int unsigned      CNT_W     = 15,
  parameter logic [CNT_W-1:0] START_VAL = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             idle_i,
  input logic             enable_i,
  input logic             refresh_i,
  input logic [CNT_W-1:0] count_i,
  input logic             rst_req_i
);
  localparam logic [CNT_W-1:0] TOP = '1;

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |-> (count_i == '0 && !rst_req_i));

  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && !refresh_i && count_i != TOP) |=>
      (count_i == $past(count_i) || count_i == $past(count_i) + CNT_W'(1)));

  p_hold_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_i && !refresh_i) |=> $stable(count_i));

  p_refresh_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_i |=> (count_i == START_VAL && !rst_req_i));

  p_req_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_i |=> !rst_req_i);

  p_req_reloads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_i |-> count_i == START_VAL);

  p_no_req_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_i |-> !$past(idle_i));

  p_req_from_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_i |-> ($past(count_i) == TOP && !$past(refresh_i)));
endmodule

bind idle_wdt idle_wdt_chk #(.CNT_W(CNT_W), .START_VAL(START_VAL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .idle_i    (idle_i),
  .enable_i  (enable_i),
  .refresh_i (refresh_i),
  .count_i   (count_o),
  .rst_req_i (rst_req_o)
);

// File: tb/idle_wdt_tb.sv
module idle_wdt_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 15;
  localparam logic [CW-1:0] SV = 15'h7FF0;

  typedef struct packed {
    logic          idle;
    logic          en;
    logic          refr;
    logic [7:0]    ncyc;
    logic [CW-1:0] cnt;
    logic          req;
    logic [3:0]    pulses;
    logic [7:0]    rid;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b0, 8'd3,  15'h0000, 1'b0, 4'd0, 8'd3}, // R3 disabled hold
    '{1'b0, 1'b1, 1'b0, 8'd4,  15'h0002, 1'b0, 4'd0, 8'd2}, // R2 two ticks
    '{1'b0, 1'b1, 1'b1, 8'd1,  15'h7FF0, 1'b0, 4'd0, 8'd4}, // R4 refresh
    '{1'b0, 1'b1, 1'b0, 8'd3,  15'h7FF1, 1'b0, 4'd0, 8'd2}, // R2
    '{1'b0, 1'b1, 1'b1, 8'd1,  15'h7FF0, 1'b0, 4'd0, 8'd4}, // R4 beats tick
    '{1'b0, 1'b0, 1'b0, 8'd5,  15'h7FF0, 1'b0, 4'd0, 8'd3}, // R3
    '{1'b1, 1'b1, 1'b0, 8'd6,  15'h7FF3, 1'b0, 4'd0, 8'd5}, // R5 idle counts
    '{1'b0, 1'b1, 1'b0, 8'd24, 15'h7FFF, 1'b0, 4'd0, 8'd2}, // R2 reach top
    '{1'b0, 1'b1, 1'b0, 8'd1,  15'h7FFF, 1'b0, 4'd0, 8'd2}, // R2 between ticks
    '{1'b0, 1'b1, 1'b0, 8'd1,  15'h7FF0, 1'b1, 4'd1, 8'd6}, // R6 overflow
    '{1'b0, 1'b1, 1'b0, 8'd1,  15'h7FF0, 1'b0, 4'd0, 8'd6}, // R6 one cycle
    '{1'b1, 1'b1, 1'b0, 8'd31, 15'h7FF0, 1'b0, 4'd0, 8'd7}, // R7 idle wrap
    '{1'b1, 1'b1, 1'b1, 8'd1,  15'h7FF0, 1'b0, 4'd0, 8'd4}, // R4 in idle
    '{1'b0, 1'b1, 1'b1, 8'd1,  15'h7FF0, 1'b0, 4'd0, 8'd4}, // R4 on idle exit
    '{1'b0, 1'b1, 1'b0, 8'd30, 15'h7FFF, 1'b0, 4'd0, 8'd2}, // R2
    '{1'b0, 1'b1, 1'b0, 8'd1,  15'h7FFF, 1'b0, 4'd0, 8'd2}, // R2
    '{1'b0, 1'b1, 1'b1, 8'd1,  15'h7FF0, 1'b0, 4'd0, 8'd8}  // R8 refresh blocks
  };

  logic          clk;
  logic          rst_n;
  logic          idle_i;
  logic          enable_i;
  logic          refresh_i;
  logic [CW-1:0] count_o;
  logic          rst_req_o;

  int checks;
  int errors;
  bit done;

  idle_wdt #(.CNT_W(CW), .PRESCALE_DIV(2), .START_VAL(SV)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle_i    (idle_i),
    .enable_i  (enable_i),
    .refresh_i (refresh_i),
    .count_o   (count_o),
    .rst_req_o (rst_req_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    done = 1'b0;
    rst_n = 1'b1;
    idle_i = 1'b0;
    enable_i = 1'b0;
    refresh_i = 1'b0;
    #2 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "count in reset", 32'(count_o), 32'h0);
    chk("R1", "req in reset", 32'(rst_req_o), 32'h0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "count after release", 32'(count_o), 32'h0);
    chk("R1", "req after release", 32'(rst_req_o), 32'h0);

    for (int v = 0; v < NV; v++) begin
      int seen;
      string tag;
      seen = 0;
      tag = $sformatf("R%0d v%0d", VEC[v].rid, v);
      idle_i    = VEC[v].idle;
      enable_i  = VEC[v].en;
      refresh_i = VEC[v].refr;
      for (int c = 0; c < int'(VEC[v].ncyc); c++) begin
        @(posedge clk);
        @(negedge clk);
        if (rst_req_o) seen++;
      end
      chk(tag, "count", 32'(count_o), 32'(VEC[v].cnt));
      chk(tag, "req", 32'(rst_req_o), 32'(VEC[v].req));
      chk(tag, "pulses", 32'(seen), 32'(VEC[v].pulses));
    end
    refresh_i = 1'b0;

    // R1: asynchronous reset assertion in mid-run
    enable_i = 1'b1;
    repeat (6) @(posedge clk);
    #(CLK_PERIOD / 4) rst_n = 1'b0;
    #1;
    chk("R1", "count async clear", 32'(count_o), 32'h0);
    chk("R1", "req async clear", 32'(rst_req_o), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    enable_i = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", "count held after reset", 32'(count_o), 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule